// File: doc/BRIEF.md
# Interrupt Cause Controller with Summary Aggregation

This block collects event pulses from three sources (receive, transmit and miscellaneous) into three 32-bit cause registers. Each group has a mask, separate strobes to set and to clear mask bits, and a per-bit choice of how a cause bit is acknowledged: by reading it, or by writing one to it. An event pulse latches its cause bit whether or not that bit is masked. The mask only decides whether the bit counts toward the group's summary bit.

A three-bit summary register records which groups have at least one unmasked cause. Software reads the summary register to learn which groups need service, and the read clears it. A separate summary mask decides which summary bits drive the single interrupt line to the host. Software uses a simple synchronous bus with one read strobe and one write strobe. Read data comes back from a register in the cycle after the strobe.

Register map (word addresses):
- Group g (receive g=0, transmit g=1, miscellaneous g=2) has its base at 8*g.
- Group offsets: +0 cause, +1 mask set, +2 mask clear, +3 mask value, +4 masked cause, +5 clear mode.
- Address 24 is the summary cause register and address 25 is the summary mask.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause bit is 0, every group mask bit is 1, every clear-mode bit is 0 (write-one-to-clear), the summary register is 0, the summary mask is all ones, and `irq_o` is low.
- R2: An event pulse bit sets the matching cause bit in the clock edge that samples it, whether or not that bit is masked. A read of the cause register (offset +0) returns the value from before any clear caused by that read.
- R3: For a cause bit whose clear-mode bit is 0, writing a word with a 1 at that position to offset +0 clears the bit. Reading the cause register leaves the bit set.
- R4: For a cause bit whose clear-mode bit (offset +5) is 1, reading offset +0 clears the bit. A write of 1 to offset +0 leaves the bit set.
- R5: When an event pulse for a bit coincides with a clearing read or a clearing write of that bit, the bit remains set.
- R6: A write to mask set (offset +1) sets every mask bit where the written word is 1 and leaves the other mask bits unchanged.
- R7: A write to mask clear (offset +2) clears every mask bit where the written word is 1 and leaves the other mask bits unchanged.
- R8: Offset +3 reads the current mask. Offset +4 reads cause AND NOT mask. Reading either register leaves every register unchanged.
- R9: Summary bit g (receive at bit 0, transmit at bit 1, miscellaneous at bit 2) is set one cycle after group g has any cause bit that is set and unmasked. The bit stays set until address 24 is read. That read returns the value from before the clear and clears every group that is not active in the same cycle.
- R10: `irq_o` is high exactly when some summary bit is set and the matching bit [2:0] of the summary mask (address 25) is 0. It follows the summary register combinationally, so it rises in the cycle after the cause state that triggers it.
- R11: `rdata_o` is updated at the clock edge that samples `rd_en_i` and holds its value otherwise. Unmapped addresses (group offsets 6 and 7, and addresses 26 to 31) read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rx_evt_i | input | 32 | Receive group event pulses |
| tx_evt_i | input | 32 | Transmit group event pulses |
| misc_evt_i | input | 32 | Miscellaneous group event pulses |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
A new event can arrive in the same cycle that software acknowledges that cause bit, either by reading a bit in clear-on-read mode or by writing one to a bit in write-one-to-clear mode. The bench drives the event bus in the same half-cycle as the read or write strobe and then reads the cause register again. That read must still show the bit set. A second collision occurs when the summary register is read while a group is still active. The summary bit must survive that read and be cleared only by a later read taken after the cause has been acknowledged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DW     = 32;
    localparam int GRP_N  = 3;
    localparam int AW     = 5;
    localparam int OFS_W  = 3;
    localparam int PAGE_W = AW - OFS_W;

    typedef enum logic [OFS_W-1:0] {
        OFS_CAUSE  = 3'd0,
        OFS_MSET   = 3'd1,
        OFS_MCLR   = 3'd2,
        OFS_MVAL   = 3'd3,
        OFS_MCAUSE = 3'd4,
        OFS_CMODE  = 3'd5
    } grp_ofs_e;

    typedef enum logic [OFS_W-1:0] {
        SOFS_CAUSE = 3'd0,
        SOFS_MASK  = 3'd1
    } sum_ofs_e;

    typedef enum logic [PAGE_W-1:0] {
        PG_RX   = 2'd0,
        PG_TX   = 2'd1,
        PG_MISC = 2'd2,
        PG_SUM  = 2'd3
    } page_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
    } reg_addr_t;

    typedef struct packed {
        logic rd_cause;
        logic wr_cause;
        logic wr_mset;
        logic wr_mclr;
        logic wr_cmode;
    } grp_stb_t;

    // New events take priority over any clear in the same cycle.
    function automatic logic [DW-1:0] cause_next(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] clr,
        input logic [DW-1:0] evt
    );
        return (cur & ~clr) | evt;
    endfunction

    // Bits to clear, given the access type and the per-bit clear mode.
    function automatic logic [DW-1:0] clear_bits(
        input grp_stb_t        stb,
        input logic [DW-1:0]   wdata,
        input logic [DW-1:0]   cmode
    );
        logic [DW-1:0] c;
        c = '0;
        if (stb.wr_cause) c = c | (wdata & ~cmode);
        if (stb.rd_cause) c = c | cmode;
        return c;
    endfunction
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group
    import irq_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt_i,
    input  grp_stb_t      stb_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cause_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] cmode_o,
    output logic          active_o
);
    logic [DW-1:0] cause_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] cmode_q;
    logic [DW-1:0] clr_w;

    always_comb clr_w = clear_bits(stb_i, wdata_i, cmode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '1;
            cmode_q <= '0;
        end else begin
            cause_q <= cause_next(cause_q, clr_w, evt_i);
            if (stb_i.wr_mset)
                mask_q <= mask_q | wdata_i;
            else if (stb_i.wr_mclr)
                mask_q <= mask_q & ~wdata_i;
            if (stb_i.wr_cmode)
                cmode_q <= wdata_i;
        end
    end

    assign cause_o  = cause_q;
    assign mask_o   = mask_q;
    assign cmode_o  = cmode_q;
    assign active_o = |(cause_q & ~mask_q);

    // R5 / R2: a pulsed event bit is set after the edge, whatever else happened
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R3: write-one-to-clear clears targeted bits in write-clear mode
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (stb_i.wr_cause && evt_i == '0) |=>
            ((cause_q & $past(wdata_i) & ~cmode_q) == '0));

    // R4: a cause read clears every clear-on-read bit
    p_cor_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (stb_i.rd_cause && evt_i == '0) |=> ((cause_q & cmode_q) == '0));

    // R6: mask set raises written bits
    p_mset_r6: assert property (@(posedge clk) disable iff (rst)
        stb_i.wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R7: mask clear lowers written bits and keeps the rest
    p_mclr_r7: assert property (@(posedge clk) disable iff (rst)
        stb_i.wr_mclr |=> (((mask_q & $past(wdata_i)) == '0) &&
            ((mask_q | $past(wdata_i)) == ($past(mask_q) | $past(wdata_i)))));
endmodule

// File: rtl/irq_summary_unit.sv
module irq_summary_unit
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_N-1:0] active_i,
    input  logic             rd_i,
    input  logic             wr_mask_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [GRP_N-1:0] sum_o,
    output logic [DW-1:0]    smask_o,
    output logic             irq_o
);
    logic [GRP_N-1:0] sum_q;
    logic [DW-1:0]    smask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            smask_q <= '1;
        end else begin
            sum_q <= (rd_i ? '0 : sum_q) | active_i;
            if (wr_mask_i)
                smask_q <= wdata_i;
        end
    end

    assign sum_o   = sum_q;
    assign smask_o = smask_q;
    assign irq_o   = |(sum_q & ~smask_q[GRP_N-1:0]);

    // R9: an active group is recorded one cycle later
    p_sum_set_r9: assert property (@(posedge clk) disable iff (rst)
        (active_i != '0) |=> ((sum_q & $past(active_i)) == $past(active_i)));

    // R9: a read with no active group empties the summary
    p_sum_rdclr_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_i && active_i == '0) |=> (sum_q == '0));

    // R9: without a read, summary bits are sticky
    p_sum_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> ((sum_q & $past(sum_q)) == $past(sum_q)));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] rx_evt_i,
    input  logic [DW-1:0] tx_evt_i,
    input  logic [DW-1:0] misc_evt_i,
    output logic          irq_o
);
    reg_addr_t        a_w;
    logic [DW-1:0]    evt_w   [GRP_N];
    logic [DW-1:0]    cause_w [GRP_N];
    logic [DW-1:0]    mask_w  [GRP_N];
    logic [DW-1:0]    cmode_w [GRP_N];
    logic [GRP_N-1:0] active_w;
    logic [GRP_N-1:0] sum_w;
    logic [DW-1:0]    smask_w;
    logic             sum_rd_w;
    logic             sum_wr_w;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    rdata_q;

    assign a_w      = reg_addr_t'(addr_i);
    assign evt_w[0] = rx_evt_i;
    assign evt_w[1] = tx_evt_i;
    assign evt_w[2] = misc_evt_i;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        grp_stb_t stb;
        logic     hit;
        assign hit          = (a_w.page == PAGE_W'(g));
        assign stb.rd_cause = rd_en_i && hit && (a_w.ofs == OFS_CAUSE);
        assign stb.wr_cause = wr_en_i && hit && (a_w.ofs == OFS_CAUSE);
        assign stb.wr_mset  = wr_en_i && hit && (a_w.ofs == OFS_MSET);
        assign stb.wr_mclr  = wr_en_i && hit && (a_w.ofs == OFS_MCLR);
        assign stb.wr_cmode = wr_en_i && hit && (a_w.ofs == OFS_CMODE);

        irq_cause_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt_w[g]),
            .stb_i    (stb),
            .wdata_i  (wdata_i),
            .cause_o  (cause_w[g]),
            .mask_o   (mask_w[g]),
            .cmode_o  (cmode_w[g]),
            .active_o (active_w[g])
        );
    end

    assign sum_rd_w = rd_en_i && (a_w.page == PG_SUM) && (a_w.ofs == SOFS_CAUSE);
    assign sum_wr_w = wr_en_i && (a_w.page == PG_SUM) && (a_w.ofs == SOFS_MASK);

    irq_summary_unit u_sum (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active_w),
        .rd_i      (sum_rd_w),
        .wr_mask_i (sum_wr_w),
        .wdata_i   (wdata_i),
        .sum_o     (sum_w),
        .smask_o   (smask_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (a_w.page == PG_SUM) begin
            if (a_w.ofs == SOFS_CAUSE)
                rd_mux = DW'(sum_w);
            else if (a_w.ofs == SOFS_MASK)
                rd_mux = smask_w;
        end else begin
            for (int g = 0; g < GRP_N; g++) begin
                if (a_w.page == PAGE_W'(g)) begin
                    case (a_w.ofs)
                        OFS_CAUSE:  rd_mux = cause_w[g];
                        OFS_MVAL:   rd_mux = mask_w[g];
                        OFS_MCAUSE: rd_mux = cause_w[g] & ~mask_w[g];
                        OFS_CMODE:  rd_mux = cmode_w[g];
                        default:    rd_mux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en_i)
            rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

    // R11: read data holds while no read is issued
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rdata_o));

    // R10: with every summary bit masked the line stays low
    p_irq_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (&smask_w[GRP_N-1:0]) |-> !irq_o);
endmodule

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] rx_evt_i = '0;
    logic [31:0] tx_evt_i = '0;
    logic [31:0] misc_evt_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rx_evt_i(rx_evt_i), .tx_evt_i(tx_evt_i), .misc_evt_i(misc_evt_i),
        .irq_o(irq_o)
    );

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 4'd1,  5'd3,  32'h0,        32'hFFFFFFFF}, // R1 rx mask value
        '{OP_EV, 4'd2,  5'd0,  32'h00000005, 32'h0},
        '{OP_RD, 4'd2,  5'd0,  32'h0,        32'h00000005}, // R2 masked event latched
        '{OP_RD, 4'd9,  5'd24, 32'h0,        32'h00000000}, // R9 masked cause not summarised
        '{OP_WR, 4'd7,  5'd2,  32'h00000001, 32'h0},
        '{OP_RD, 4'd7,  5'd3,  32'h0,        32'hFFFFFFFE}, // R7 mask clear
        '{OP_RD, 4'd8,  5'd4,  32'h0,        32'h00000001}, // R8 masked view
        '{OP_RD, 4'd8,  5'd0,  32'h0,        32'h00000005}, // R8 view read cleared nothing
        '{OP_RD, 4'd9,  5'd24, 32'h0,        32'h00000001}, // R9 rx summary bit
        '{OP_WR, 4'd3,  5'd0,  32'h00000004, 32'h0},
        '{OP_RD, 4'd3,  5'd0,  32'h0,        32'h00000001}, // R3 write-one clear
        '{OP_RD, 4'd3,  5'd0,  32'h0,        32'h00000001}, // R3 read does not clear
        '{OP_WR, 4'd3,  5'd0,  32'h00000001, 32'h0},
        '{OP_RD, 4'd9,  5'd24, 32'h0,        32'h00000001}, // R9 sticky after cause gone
        '{OP_RD, 4'd9,  5'd24, 32'h0,        32'h00000000}, // R9 cleared by read
        '{OP_WR, 4'd4,  5'd13, 32'h000000F0, 32'h0},
        '{OP_RD, 4'd4,  5'd13, 32'h0,        32'h000000F0}, // R4 clear mode readback
        '{OP_EV, 4'd4,  5'd1,  32'h000000F3, 32'h0},
        '{OP_RD, 4'd4,  5'd8,  32'h0,        32'h000000F3}, // R4 pre-clear value
        '{OP_RD, 4'd4,  5'd8,  32'h0,        32'h00000003}, // R4 read cleared mode bits
        '{OP_WR, 4'd3,  5'd8,  32'h00000001, 32'h0},
        '{OP_EV, 4'd4,  5'd1,  32'h00000010, 32'h0},
        '{OP_WR, 4'd4,  5'd8,  32'h00000010, 32'h0},
        '{OP_RD, 4'd4,  5'd8,  32'h0,        32'h00000012}, // R4 write ignored on read-clear bit
        '{OP_RD, 4'd3,  5'd8,  32'h0,        32'h00000002}, // R3 write-one cleared bit 0
        '{OP_WR, 4'd7,  5'd18, 32'hFFFF0000, 32'h0},
        '{OP_WR, 4'd6,  5'd17, 32'h00FF0000, 32'h0},
        '{OP_RD, 4'd6,  5'd19, 32'h0,        32'h00FFFFFF}  // R6 mask set
    };

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic pulse(input int g, input logic [31:0] bits);
        @(negedge clk);
        if (g == 0) rx_evt_i = bits;
        else if (g == 1) tx_evt_i = bits;
        else misc_evt_i = bits;
        @(negedge clk);
        rx_evt_i = '0; tx_evt_i = '0; misc_evt_i = '0;
    endtask

    task automatic rd_chk(input int req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(1, {31'b0, irq_o}, 32'h0);
        rd_chk(1, 5'd0, 32'h0);
        rd_chk(1, 5'd8, 32'h0);
        rd_chk(1, 5'd16, 32'h0);
        rd_chk(1, 5'd11, 32'hFFFFFFFF);
        rd_chk(1, 5'd19, 32'hFFFFFFFF);
        rd_chk(1, 5'd5, 32'h0);
        rd_chk(1, 5'd25, 32'hFFFFFFFF);
        rd_chk(1, 5'd24, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data);
                OP_RD: rd_chk(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
                default: pulse(int'(VEC[i].addr), VEC[i].data);
            endcase
        end

        // R5 event collides with clearing read (bit 8 clear-on-read)
        wr(5'd5, 32'h00000100);
        pulse(0, 32'h00000100);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = 5'd0; rx_evt_i = 32'h00000100;
        @(negedge clk);
        rd_en_i = 1'b0; rx_evt_i = '0;
        chk(5, rdata_o, 32'h00000100);
        rd_chk(5, 5'd0, 32'h00000100);
        rd_chk(4, 5'd0, 32'h00000000);

        // R5 event collides with write-one clear (bit 9)
        pulse(0, 32'h00000200);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 5'd0; wdata_i = 32'h00000200; rx_evt_i = 32'h00000200;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0; rx_evt_i = '0;
        rd_chk(5, 5'd0, 32'h00000200);
        wr(5'd0, 32'h00000200);
        rd_chk(3, 5'd0, 32'h00000000);

        // R10 interrupt line timing and gating
        wr(5'd25, 32'hFFFFFFF8);
        chk(10, {31'b0, irq_o}, 32'h0);
        pulse(0, 32'h00000001);
        chk(10, {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk(10, {31'b0, irq_o}, 32'h1);
        wr(5'd25, 32'hFFFFFFFF);
        chk(10, {31'b0, irq_o}, 32'h0);
        wr(5'd25, 32'hFFFFFFFE);
        chk(10, {31'b0, irq_o}, 32'h1);
        wr(5'd25, 32'hFFFFFFFD);
        chk(10, {31'b0, irq_o}, 32'h0);
        wr(5'd25, 32'hFFFFFFF8);
        // R9 read while active keeps the bit
        rd_chk(9, 5'd24, 32'h00000001);
        chk(9, {31'b0, irq_o}, 32'h1);
        wr(5'd0, 32'h00000001);
        rd_chk(9, 5'd24, 32'h00000001);
        chk(10, {31'b0, irq_o}, 32'h0);
        rd_chk(9, 5'd24, 32'h00000000);

        // R11 unmapped addresses
        wr(5'd30, 32'hDEADBEEF);
        wr(5'd6, 32'hDEADBEEF);
        rd_chk(11, 5'd30, 32'h0);
        rd_chk(11, 5'd6, 32'h0);
        rd_chk(11, 5'd26, 32'h0);
        rd_chk(11, 5'd3, 32'hFFFFFFFE);
        rd_chk(11, 5'd25, 32'hFFFFFFF8);
        @(negedge clk);
        @(negedge clk);
        chk(11, rdata_o, 32'hFFFFFFF8);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule